// File: doc/BRIEF.md
# UART framer with per-bit timing trim

This block serializes one byte at a time onto a UART transmit line. A byte is offered with a valid/ready handshake. The block samples the byte and its configuration in the cycle it accepts them. The configuration is a baud divisor, a 6-bit line-format word and a 24-bit trim word. The block then drives a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. The busy flag stays high for the whole frame.

Every bit is built from 16 sub-ticks. Each sub-tick lasts divisor+1 clock cycles. A 2-bit trim code for each frame position can make that bit 17 sub-ticks long or 15 sub-ticks short. This allows small adjustments to the timing of the whole frame. A break request holds the line low once the frame in progress has finished.

Top module: `uart_trim_tx`

## Requirements
- R1: After reset, tx_o is high, busy_o is low and ready_o is high (with brk_i low).
- R2: With trim code 0, a bit lasts exactly 16*(div_i+1) clock cycles.
- R3: The trim code for frame position p is trim_i[2p+1:2p]. Code 1 makes that bit 17*(div_i+1) cycles long, code 3 makes it 15*(div_i+1) cycles long, and codes 0 and 2 leave it at 16*(div_i+1) cycles.
- R4: fmt_i[1:0] selects 5, 6, 7 or 8 data bits for the values 0, 1, 2 and 3. The frame is position 0 = start bit (low), then the data bits least significant first.
- R5: fmt_i[2] = 0 gives one stop bit and fmt_i[2] = 1 gives two stop bits. Stop bits are high, and the line stays high after the frame.
- R6: fmt_i[5:3] selects the parity bit, which follows the data bits. The value 4 gives odd parity over the data bits and 5 gives even parity. The value 6 sends a 1 and 7 sends a 0. Any other value sends no parity bit.
- R7: Trim codes at positions beyond the configured frame length have no effect. The frame ends after its own last stop bit.
- R8: ready_o is high only while no frame is in progress and brk_i is low. A byte is accepted when valid_i and ready_o are both high. busy_o is high from the cycle after acceptance until the last bit ends. Changes to data_i, div_i, fmt_i or trim_i during a frame have no effect on that frame.
- R9: While brk_i is high and no frame is in progress, tx_o is driven low from the next cycle and ready_o is low. A frame in progress when brk_i rises finishes unchanged. tx_o returns high in the cycle after brk_i falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Byte can be accepted |
| div_i | input | DIV_W | Baud divisor; a sub-tick lasts div_i+1 cycles |
| fmt_i | input | 6 | {parity[2:0], two_stop, data_len[1:0]} |
| trim_i | input | 24 | 2-bit trim code per frame position |
| brk_i | input | 1 | Hold the line low when idle |
| tx_o | output | 1 | Serial output |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong sub-tick count inside the bit timer displaces the next edge on tx_o. The error shows in the first cycle of that bit's expected end, so the bench compares the level of every cycle against the expected bit widths. A wrong position counter or a corrupted frame image shows as a wrong level in the following bit, or as a frame that ends early or late. A late end shows as busy_o still high, or ready_o still low, in the cycle after the expected last stop bit. Alternating data patterns keep neighbouring bits at different levels, so an edge cannot hide between two equal bits.

// File: rtl/uart_trim_pkg.sv
package uart_trim_pkg;
  localparam int MAX_BITS = 12;
  localparam int CODE_W   = 2;
  localparam int TRIM_W   = MAX_BITS * CODE_W;
  localparam int POS_W    = $clog2(MAX_BITS);
  localparam int SUB_W    = 5;

  typedef struct packed {
    logic [2:0] parity;
    logic       two_stop;
    logic [1:0] dlen;
  } fmt_t;

  function automatic logic [SUB_W-1:0] sub_count(input logic [CODE_W-1:0] code);
    case (code)
      2'd1:    return SUB_W'(17);
      2'd3:    return SUB_W'(15);
      default: return SUB_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/uart_trim_prescale.sv
module uart_trim_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_trim_bit_timer.sv
module uart_trim_bit_timer
  import uart_trim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SUB_W-1:0] len_i,
  output logic             done_o
);
  logic [SUB_W-1:0] sub_q;

  assign done_o = tick_i && (sub_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sub_q <= '0;
    else if (!run_i || done_o) sub_q <= '0;
    else if (tick_i)           sub_q <= sub_q + 1'b1;
  end
endmodule

// File: rtl/uart_trim_frame_build.sv
module uart_trim_frame_build
  import uart_trim_pkg::*;
(
  input  logic [7:0]          data_i,
  input  fmt_t                fmt_i,
  output logic [MAX_BITS-1:0] bits_o,
  output logic [POS_W-1:0]    nbits_o
);
  int  nd;
  int  n;
  logic has_par;
  logic ones;
  logic pbit;

  always_comb begin
    nd      = 5 + int'(fmt_i.dlen);
    has_par = fmt_i.parity[2];
    ones    = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < nd) ones = ones ^ data_i[i];
    case (fmt_i.parity)
      3'd4:    pbit = ~ones;
      3'd5:    pbit = ones;
      3'd6:    pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    bits_o    = '1;           // stop bits and unused tail stay high
    bits_o[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < nd) bits_o[1+i] = data_i[i];
    if (has_par) bits_o[1+nd] = pbit;
    n       = 2 + nd + int'(has_par) + int'(fmt_i.two_stop);
    nbits_o = POS_W'(n);
  end
endmodule

// File: rtl/uart_trim_tx.sv
module uart_trim_tx
  import uart_trim_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [5:0]        fmt_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              brk_i,
  output logic              tx_o,
  output logic              busy_o
);
  logic                busy_q, tx_q;
  logic [MAX_BITS-1:0] bits_q, fb_bits;
  logic [POS_W-1:0]    nbits_q, fb_nbits, pos_q, pos_nx;
  logic [TRIM_W-1:0]   trim_q;
  logic [DIV_W-1:0]    div_q;
  logic [SUB_W-1:0]    len_tab [MAX_BITS];
  logic [SUB_W-1:0]    cur_len;
  logic                tick, bit_done, accept;

  assign ready_o = !busy_q && !brk_i;
  assign accept  = valid_i && ready_o;
  assign pos_nx  = pos_q + 1'b1;

  uart_trim_frame_build u_build (
    .data_i (data_i),
    .fmt_i  (fmt_t'(fmt_i)),
    .bits_o (fb_bits),
    .nbits_o(fb_nbits)
  );

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_len
    assign len_tab[g] = sub_count(trim_q[g*CODE_W +: CODE_W]);
  end

  assign cur_len = len_tab[pos_q];

  uart_trim_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .div_i (div_q),
    .tick_o(tick)
  );

  uart_trim_bit_timer u_bit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .tick_i(tick),
    .len_i (cur_len),
    .done_o(bit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tx_q    <= 1'b1;
      bits_q  <= '1;
      nbits_q <= '0;
      pos_q   <= '0;
      trim_q  <= '0;
      div_q   <= '0;
    end else if (!busy_q) begin
      if (accept) begin
        busy_q  <= 1'b1;
        bits_q  <= fb_bits;
        nbits_q <= fb_nbits;
        trim_q  <= trim_i;
        div_q   <= div_i;
        pos_q   <= '0;
        tx_q    <= fb_bits[0];
      end else begin
        tx_q <= !brk_i;
      end
    end else if (bit_done) begin
      if (pos_q == nbits_q - 1'b1) begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_nx;
        tx_q  <= bits_q[pos_nx];
      end
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/uart_trim_tx_chk.sv
module uart_trim_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic brk_i,
  input logic tx_o,
  input logic busy_o
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && !$past(brk_i)) |-> tx_o);

  assert_start_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);

  assert_end_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> tx_o);

  assert_ready_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && !brk_i));

  assert_accept_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> busy_o);

  assert_break_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!busy_o && brk_i) |-> (!tx_o && !busy_o));
endmodule

bind uart_trim_tx uart_trim_tx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .ready_o(ready_o),
  .brk_i  (brk_i),
  .tx_o   (tx_o),
  .busy_o (busy_o)
);

// File: tb/sim_uart_trim_tx.sv
module sim_uart_trim_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [15:0] div_i = '0;
  logic [5:0]  fmt_i = '0;
  logic [23:0] trim_i = '0;
  logic        brk_i = 1'b0;
  logic        tx_o, busy_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  uart_trim_tx u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // fmt = {parity[2:0], two_stop, dlen[1:0]}
  task automatic send(input [7:0] d, input [5:0] f, input [23:0] tr, input [15:0] dv,
                      input bit brk_mid, input string req);
    logic lv[12];
    int   w[12];
    int   n, nd, p;
    logic ones;
    nd = 5 + int'(f[1:0]);
    ones = 1'b0;
    for (int i = 0; i < 12; i++) lv[i] = 1'b1;
    lv[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin lv[1+i] = d[i]; ones ^= d[i]; end
    n = 1 + nd;
    if (f[5]) begin
      case (f[5:3])
        3'd4: lv[n] = ~ones;
        3'd5: lv[n] = ones;
        3'd6: lv[n] = 1'b1;
        default: lv[n] = 1'b0;
      endcase
      n++;
    end
    n += 1 + int'(f[2]);
    for (int i = 0; i < 12; i++) begin
      p = (tr[2*i +: 2] == 2'd1) ? 17 : (tr[2*i +: 2] == 2'd3) ? 15 : 16;
      w[i] = p * (int'(dv) + 1);
    end
    @(negedge clk_i);
    data_i = d; fmt_i = f; trim_i = tr; div_i = dv; valid_i = 1'b1;
    chk(ready_o === 1'b1, req, "ready before accept", int'(ready_o), 1);
    @(posedge clk_i);
    for (int b = 0; b < n; b++) begin
      int bad = 0;
      int got = int'(lv[b]);
      for (int c = 0; c < w[b]; c++) begin
        @(negedge clk_i);
        if (b == 0 && c == 0) begin
          // R8: inputs change mid-frame, must not matter
          valid_i = 1'b0; data_i = ~d; fmt_i = ~f; trim_i = ~tr; div_i = dv + 16'd1;
        end
        if (brk_mid && b == 1 && c == 0) brk_i = 1'b1;
        if (tx_o !== lv[b] || busy_o !== 1'b1 || ready_o !== 1'b0) begin
          if (bad == 0) got = int'(tx_o);
          bad++;
        end
      end
      chk(bad == 0, req, $sformatf("bit %0d level over %0d cycles", b, w[b]), got, int'(lv[b]));
    end
    @(negedge clk_i);
    chk(tx_o === 1'b1 && busy_o === 1'b0, req, "line high and idle after frame",
        int'({tx_o, busy_o}), 2);
    chk(ready_o === !brk_mid, req, "ready after frame", int'(ready_o), int'(!brk_mid));
  endtask

  task automatic t_reset;
    chk(tx_o === 1'b1, "R1", "tx after reset", int'(tx_o), 1);
    chk(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    chk(ready_o === 1'b1, "R1", "ready after reset", int'(ready_o), 1);
  endtask

  task automatic t_nominal;
    send(8'h55, 6'b000_0_11, 24'h0, 16'd0, 1'b0, "R2");
    send(8'hA5, 6'b000_0_11, 24'h0, 16'd2, 1'b0, "R2");
    send(8'h2A, 6'b000_1_11, 24'haaaaaa, 16'd1, 1'b0, "R3"); // code 2 = no change
  endtask

  task automatic t_trim;
    logic [23:0] tr = '0;
    for (int p = 0; p < 12; p++) tr[2*p +: 2] = 2'(p % 4);
    send(8'h55, 6'b000_1_11, tr, 16'd0, 1'b0, "R3");
    send(8'hAA, 6'b101_0_11, 24'hffffff, 16'd1, 1'b0, "R3");
    send(8'h55, 6'b101_1_11, 24'h555555, 16'd0, 1'b0, "R3");
  endtask

  task automatic t_lengths;
    send(8'h15, 6'b000_0_00, 24'h0, 16'd0, 1'b0, "R4");
    send(8'h2A, 6'b000_1_01, 24'h0, 16'd0, 1'b0, "R4");
    send(8'h55, 6'b000_0_10, 24'h0, 16'd0, 1'b0, "R4");
    send(8'h0A, 6'b000_1_00, 24'h0, 16'd0, 1'b0, "R5");
  endtask

  task automatic t_parity;
    send(8'h07, 6'b100_0_11, 24'h0, 16'd0, 1'b0, "R6");
    send(8'h07, 6'b101_0_11, 24'h0, 16'd0, 1'b0, "R6");
    send(8'hE2, 6'b100_0_00, 24'h0, 16'd0, 1'b0, "R6"); // only low 5 bits count
    send(8'h00, 6'b110_0_11, 24'h0, 16'd0, 1'b0, "R6");
    send(8'hFF, 6'b111_0_11, 24'h0, 16'd0, 1'b0, "R6");
    send(8'h55, 6'b011_0_11, 24'h0, 16'd0, 1'b0, "R6"); // reserved: none
  endtask

  task automatic t_ignore;
    // 5N1 = 7 positions; positions 7..11 carry lengthen/shorten codes
    send(8'h15, 6'b000_0_00, 24'h555_000 | 24'hffc000, 16'd0, 1'b0, "R7");
    send(8'h15, 6'b000_0_00, 24'hffc000, 16'd1, 1'b0, "R7");
  endtask

  task automatic t_handshake;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0 && tx_o === 1'b1, "R8", "no start without valid",
        int'({busy_o, tx_o}), 1);
  endtask

  task automatic t_break;
    int bad = 0;
    send(8'h55, 6'b000_0_11, 24'h0, 16'd0, 1'b1, "R9");
    @(negedge clk_i);
    chk(tx_o === 1'b0, "R9", "tx low during break", int'(tx_o), 0);
    valid_i = 1'b1; data_i = 8'hFF;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk_i);
      if (tx_o !== 1'b0 || busy_o !== 1'b0 || ready_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R9", "break blocks frames", bad, 0);
    valid_i = 1'b0;
    brk_i = 1'b0;
    @(negedge clk_i);
    chk(tx_o === 1'b1 && ready_o === 1'b1, "R9", "line released after break",
        int'({tx_o, ready_o}), 3);
    @(negedge clk_i);
    brk_i = 1'b1;
    @(negedge clk_i);
    chk(tx_o === 1'b0, "R9", "idle break low next cycle", int'(tx_o), 0);
    brk_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_nominal();
    t_trim();
    t_lengths();
    t_parity();
    t_ignore();
    t_handshake();
    t_break();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule